// File: doc/BRIEF.md
# Root Hub Port Status and Control Bank

This block holds the status and control word of every downstream port of a USB host root hub. Each port has one 32-bit word at its own address on a simple register bus. The first word is at 0x44, and each further port adds 4. Software uses the word to switch port power and to drive a bus reset for as long as it wants. It reads whether a device is attached and whether the port is enabled. It also sees two sticky flags that record changes of those two states until software acknowledges them.

The connect input of each port comes from a line interface that has already debounced it. The block drives one power-enable line and one reset line per port. The port enables itself only at the moment software ends a reset while a device is still attached. It disables itself when the device goes away or power is removed. Software may disable a port but can never enable one directly.

The parameter `POWER_SWITCHED` selects between switchable port power and power that is always present. Reads are registered and return data one clock after the read strobe.

Top module: `root_port_bank`

## Requirements
- R1: After reset every port word reads 0x0000_0000, and `port_power_o` and `port_reset_o` are all low.
- R2: Port i (counting from 0) answers at address 0x44 + 4*i. A read strobe returns the word on `reg_rdata` one clock later. Reads of other addresses return 0, and writes to other addresses change no port.
- R3: Bit 0 of a port word reads 1 when the port is powered and its connect input is high. It follows that input one clock after the input changes.
- R4: Bit 1 (connect change) sets whenever bit 0 changes value, on attach or on detach.
- R5: Bits 1 and 3 are write-1-to-clear. Writing 1 to one of them clears only that flag, and writing 0 leaves it as it was. A hardware event in the same cycle wins over the clear.
- R6: Bit 8 (reset) is read/write. While it is set and the port is powered, `port_reset_o` is high. Setting it disables the port without setting bit 3.
- R7: When a write clears bit 8 and a device is attached, bit 2 (enabled) and bit 3 (enable change) both set. If no device is attached, the port stays disabled.
- R8: Writing 1 to bit 2 has no effect. Writing 0 to bit 2 disables the port and does not set bit 3.
- R9: When the device detaches from an enabled port, bit 2 clears and bit 3 sets.
- R10: Bit 12 (power) is read/write and drives `port_power_o`. While power is off, the connect input is ignored and bits 0 and 2 read 0. If power is removed from an enabled port, bits 1 and 3 set.
- R11: Each port keeps its own state. Writes and line changes on one port leave every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data, valid the clock after `reg_re` |
| line_connect | input | NPORTS | Debounced device-present input, one per port |
| port_power_o | output | NPORTS | Power enable, one per port |
| port_reset_o | output | NPORTS | Bus reset drive, one per port |

## Verification
Every effect of a write is visible on the outputs and in the register contents after the clock edge that samples the write strobe. A change on a connect input appears in bit 0, bit 1, bit 2 and bit 3 one edge after the input changes. Removing power takes two edges to clear the connection: one edge updates the power bit, and the next edge clears the connection. The bench applies each stimulus at a falling edge and waits at least two edges before it reads. A read result is compared at the falling edge after the rising edge that saw the read strobe, so every comparison falls one cycle after the strobe, as R2 requires.

// File: rtl/root_port_pkg.sv
package root_port_pkg;

   // Width of the meaningful part of a port word
   localparam int unsigned ST_W  = 16;

   // Field positions that driver software decodes
   localparam int unsigned B_CONN = 0;
   localparam int unsigned B_CSC  = 1;
   localparam int unsigned B_EN   = 2;
   localparam int unsigned B_PEC  = 3;
   localparam int unsigned B_RST  = 8;
   localparam int unsigned B_PWR  = 12;

   typedef struct packed {
      logic pwr;
      logic rst;
      logic pec;
      logic en;
      logic csc;
      logic conn;
   } port_state_t;

   function automatic logic [ST_W-1:0] pack_status(port_state_t s);
      logic [ST_W-1:0] w;
      w         = '0;
      w[B_CONN] = s.conn;
      w[B_CSC]  = s.csc;
      w[B_EN]   = s.en;
      w[B_PEC]  = s.pec;
      w[B_RST]  = s.rst;
      w[B_PWR]  = s.pwr;
      return w;
   endfunction

endpackage

// File: rtl/root_port_decode.sv
module root_port_decode #(
   parameter int unsigned NPORTS  = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned BASE    = 'h44,
   parameter int unsigned STRIDE  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NPORTS-1:0] sel
);

   genvar gi;
   generate
      for (gi = 0; gi < NPORTS; gi++) begin : g_sel
         localparam int unsigned PADDR = BASE + STRIDE * gi;
         assign sel[gi] = (addr == ADDR_W'(PADDR));
      end
   endgenerate

endmodule

// File: rtl/root_port_cell.sv
module root_port_cell
   import root_port_pkg::*;
#(
   parameter bit POWER_SWITCHED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [ST_W-1:0]   wdata,
   input  logic              line_conn,
   output port_state_t       st
);

   logic pwr_q;
   logic rst_q, conn_q, csc_q, en_q, pec_q;
   logic rst_d, conn_d, csc_d, en_d, pec_d;
   logic reset_done, pec_hw;

   // Power: switchable register or permanently on
   generate
      if (POWER_SWITCHED) begin : g_pwr_sw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pwr_q <= 1'b0;
            else if (wr_hit) pwr_q <= wdata[B_PWR];
         end
      end else begin : g_pwr_fixed
         assign pwr_q = 1'b1;
      end
   endgenerate

   always_comb begin
      conn_d     = pwr_q & line_conn;
      rst_d      = wr_hit ? wdata[B_RST] : rst_q;
      reset_done = rst_q & ~rst_d;
      en_d       = en_q;
      pec_hw     = 1'b0;
      // software may only disable
      if (wr_hit && !wdata[B_EN]) en_d = 1'b0;
      // reset in progress keeps the port disabled
      if (rst_d) en_d = 1'b0;
      // reset finished with a device present
      if (reset_done && conn_d) begin
         en_d   = 1'b1;
         pec_hw = 1'b1;
      end
      // device gone or power lost
      if (!conn_d) begin
         if (en_q) pec_hw = 1'b1;
         en_d = 1'b0;
      end
      csc_d = (conn_d != conn_q) | (csc_q & ~(wr_hit & wdata[B_CSC]));
      pec_d = pec_hw | (pec_q & ~(wr_hit & wdata[B_PEC]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q  <= 1'b0;
         conn_q <= 1'b0;
         csc_q  <= 1'b0;
         en_q   <= 1'b0;
         pec_q  <= 1'b0;
      end else begin
         rst_q  <= rst_d;
         conn_q <= conn_d;
         csc_q  <= csc_d;
         en_q   <= en_d;
         pec_q  <= pec_d;
      end
   end

   assign st = '{pwr: pwr_q, rst: rst_q, pec: pec_q, en: en_q, csc: csc_q, conn: conn_q};

endmodule

// File: rtl/root_port_rdmux.sv
module root_port_rdmux
   import root_port_pkg::*;
#(
   parameter int unsigned NPORTS = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   re,
   input  logic [NPORTS-1:0]      sel,
   input  logic [NPORTS*ST_W-1:0] stat_flat,
   output logic [DATA_W-1:0]      rdata
);

   logic [ST_W-1:0] word;

   always_comb begin
      word = '0;
      for (int i = 0; i < NPORTS; i++) begin
         if (sel[i]) word = word | stat_flat[i*ST_W +: ST_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= DATA_W'(word);
   end

endmodule

// File: rtl/root_port_bank.sv
module root_port_bank
   import root_port_pkg::*;
#(
   parameter int unsigned NPORTS         = 4,
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned BASE           = 'h44,
   parameter int unsigned STRIDE         = 4,
   parameter bit          POWER_SWITCHED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_re,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NPORTS-1:0] line_connect,
   output logic [NPORTS-1:0] port_power_o,
   output logic [NPORTS-1:0] port_reset_o
);

   localparam int unsigned LAST_ADDR = BASE + STRIDE * (NPORTS - 1);

   generate
      if (NPORTS < 1 || NPORTS > 15) begin : g_bad_nports
         $error("root_port_bank: NPORTS must be 1..15");
      end
      if (DATA_W < ST_W) begin : g_bad_dw
         $error("root_port_bank: DATA_W must hold the port word");
      end
      if (STRIDE < 1) begin : g_bad_stride
         $error("root_port_bank: STRIDE must be nonzero");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
         $error("root_port_bank: ADDR_W too small for the port range");
      end
   endgenerate

   logic [NPORTS-1:0]      sel;
   logic [NPORTS*ST_W-1:0] stat_flat;
   port_state_t            st [NPORTS];
   logic [NPORTS-1:0]      conn_v, csc_v, en_v, pec_v;

   root_port_decode #(
      .NPORTS (NPORTS),
      .ADDR_W (ADDR_W),
      .BASE   (BASE),
      .STRIDE (STRIDE)
   ) i_decode (
      .addr (reg_addr),
      .sel  (sel)
   );

   genvar gp;
   generate
      for (gp = 0; gp < NPORTS; gp++) begin : g_port
         root_port_cell #(
            .POWER_SWITCHED (POWER_SWITCHED)
         ) i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (reg_we & sel[gp]),
            .wdata     (reg_wdata[ST_W-1:0]),
            .line_conn (line_connect[gp]),
            .st        (st[gp])
         );
         assign stat_flat[gp*ST_W +: ST_W] = pack_status(st[gp]);
         assign port_power_o[gp] = st[gp].pwr;
         assign port_reset_o[gp] = st[gp].rst & st[gp].pwr;
         assign conn_v[gp]       = st[gp].conn;
         assign csc_v[gp]        = st[gp].csc;
         assign en_v[gp]         = st[gp].en;
         assign pec_v[gp]        = st[gp].pec;
      end
   endgenerate

   root_port_rdmux #(
      .NPORTS (NPORTS),
      .DATA_W (DATA_W)
   ) i_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .re        (reg_re),
      .sel       (sel),
      .stat_flat (stat_flat),
      .rdata     (reg_rdata)
   );

endmodule

// File: rtl/root_port_bank_chk.sv
module root_port_bank_chk #(
   parameter int unsigned NPORTS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPORTS-1:0] pwr_o,
   input logic [NPORTS-1:0] rst_o,
   input logic [NPORTS-1:0] conn_v,
   input logic [NPORTS-1:0] csc_v,
   input logic [NPORTS-1:0] en_v,
   input logic [NPORTS-1:0] pec_v
);

   genvar gc;
   generate
      for (gc = 0; gc < NPORTS; gc++) begin : g_chk
         // R10
         unpowered_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_o[gc] |=> (!conn_v[gc] && !en_v[gc]));
         // R9
         enable_needs_device_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_v[gc] |-> conn_v[gc]);
         // R6
         reset_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_o[gc] |-> !en_v[gc]);
         // R4
         connect_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conn_v[gc] != $past(conn_v[gc])) |-> csc_v[gc]);
         // R7
         enable_at_reset_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_v[gc]) |-> ($fell(rst_o[gc]) && pec_v[gc]));
         // R9
         detach_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(en_v[gc]) && $fell(conn_v[gc])) |-> pec_v[gc]);
      end
   endgenerate

endmodule

bind root_port_bank root_port_bank_chk #(.NPORTS(NPORTS)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .pwr_o  (port_power_o),
   .rst_o  (port_reset_o),
   .conn_v (conn_v),
   .csc_v  (csc_v),
   .en_v   (en_v),
   .pec_v  (pec_v)
);

// File: tb/test_root_port_bank.sv
`timescale 1ns/1ps
module test_root_port_bank;

   localparam int NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_re = 1'b0;
   logic [31:0] reg_rdata;
   logic [NP-1:0] line_connect = '0;
   logic [NP-1:0] port_power_o;
   logic [NP-1:0] port_reset_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   root_port_bank i_root_port_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_addr     (reg_addr),
      .reg_we       (reg_we),
      .reg_wdata    (reg_wdata),
      .reg_re       (reg_re),
      .reg_rdata    (reg_rdata),
      .line_connect (line_connect),
      .port_power_o (port_power_o),
      .port_reset_o (port_reset_o)
   );

   function automatic logic [7:0] paddr(int i);
      return 8'(8'h44 + 4 * i);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   // driver: issue a read and queue the expected word
   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_addr = a;
      reg_re   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_re   = 1'b0;
   endtask

   // monitor: compare read data one clock after the strobe
   initial begin
      forever begin
         @(posedge clk);
         if (reg_re) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               check("R2 unexpected read", reg_rdata, 32'h0);
            end else begin
               check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd(paddr(0), 32'h0, "R1 port0 word");
      rd(paddr(3), 32'h0, "R1 port3 word");
      check("R1 power outputs", 32'(port_power_o), 32'h0);
      check("R1 reset outputs", 32'(port_reset_o), 32'h0);

      // R10 line ignored while unpowered
      line_connect[0] = 1'b1;
      idle(3);
      rd(paddr(0), 32'h0, "R10 unpowered ignores connect");

      // R3 R4 power on with device present
      wr(paddr(0), 32'h1000);
      idle(2);
      check("R10 power output", 32'(port_power_o[0]), 32'h1);
      rd(paddr(0), 32'h1003, "R3 R4 connect seen");

      // R5 acknowledge connect change
      wr(paddr(0), 32'h1002);
      rd(paddr(0), 32'h1001, "R5 connect change cleared");

      // R6 reset
      wr(paddr(0), 32'h1100);
      check("R6 reset drive", 32'(port_reset_o[0]), 32'h1);
      rd(paddr(0), 32'h1101, "R6 reset bit held");

      // R7 reset end with device
      wr(paddr(0), 32'h1000);
      check("R6 reset released", 32'(port_reset_o[0]), 32'h0);
      rd(paddr(0), 32'h100D, "R7 enabled after reset");
      wr(paddr(0), 32'h100C);
      rd(paddr(0), 32'h1005, "R5 enable change cleared");

      // R8 writing 1 to enable has no effect, 0 disables silently
      wr(paddr(0), 32'h1004);
      rd(paddr(0), 32'h1005, "R8 enable write one");
      wr(paddr(0), 32'h1000);
      rd(paddr(0), 32'h1001, "R8 software disable");

      // re-enable, then R9 detach
      wr(paddr(0), 32'h1100);
      wr(paddr(0), 32'h1000);
      wr(paddr(0), 32'h100C);
      rd(paddr(0), 32'h1005, "R7 enabled again");
      line_connect[0] = 1'b0;
      idle(2);
      rd(paddr(0), 32'h100A, "R9 detach flags");

      // R5 individual clear
      wr(paddr(0), 32'h1002);
      rd(paddr(0), 32'h1008, "R5 only connect change cleared");
      wr(paddr(0), 32'h1008);
      rd(paddr(0), 32'h1000, "R5 enable change cleared");

      // R7 reset end with no device
      wr(paddr(0), 32'h1100);
      wr(paddr(0), 32'h1000);
      rd(paddr(0), 32'h1000, "R7 no device stays disabled");

      // R11 port 2 independent
      line_connect[2] = 1'b1;
      wr(paddr(2), 32'h1000);
      idle(2);
      rd(paddr(2), 32'h1003, "R11 port2 connect");
      rd(paddr(0), 32'h1000, "R11 port0 untouched");
      check("R11 power outputs", 32'(port_power_o), 32'h5);

      // R10 power loss on an enabled port
      wr(paddr(2), 32'h1002);
      wr(paddr(2), 32'h1100);
      wr(paddr(2), 32'h1000);
      wr(paddr(2), 32'h100C);
      rd(paddr(2), 32'h1005, "R7 port2 enabled");
      wr(paddr(2), 32'h0004);
      idle(2);
      check("R10 power removed", 32'(port_power_o[2]), 32'h0);
      rd(paddr(2), 32'h000A, "R10 power loss flags");

      // R2 unmapped addresses
      wr(8'h45, 32'h0000);
      wr(8'h54, 32'h1000);
      rd(paddr(0), 32'h1000, "R2 misaligned write ignored");
      rd(8'h54, 32'h0, "R2 unmapped read");
      rd(8'h40, 32'h0, "R2 below base read");

      idle(2);
      wait (exp_q.size() == 0);
      idle(1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule